// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a logical address, made of a 16-bit segment or selector value and an offset, into a linear address. A mode bit chooses between two translation paths. The flat path multiplies the segment value by sixteen and adds the low sixteen offset bits, which gives a 20-bit address. The table path treats the 16-bit value as a selector. The selector points at a 64-bit descriptor in one of two internal tables, one global and one local. The unit unpacks the split base and limit fields of that descriptor, scales the limit when the granularity flag is set, and checks the presence bit and the limit. It then returns either the base plus the offset, or a fault with a cause code.

Software fills both tables through a write port that takes one entry per cycle. Requests use a valid/ready handshake. Each accepted request gets exactly one response on the following cycle, so back-to-back requests stream at one per cycle.

Top module: `seg_xlate_unit`

## Requirements
- R1: With `req_prot`=0 the response never faults. `rsp_lin[19:0]` = (`req_sel`*16 + `req_ofs[15:0]`) mod 2^20 and `rsp_lin[31:20]`=0. `req_ofs[31:16]` has no effect.
- R2: With `req_prot`=1 the table index is `req_sel[15:3]`. `req_sel[2]`=0 selects the global table and 1 selects the local table. `req_sel[1:0]` has no effect.
- R3: Descriptor layout: limit[15:0] sits in bits 15:0, base[23:0] in bits 39:16, the access byte in bits 47:40, limit[19:16] in bits 51:48, the flags in bits 55:52 and base[31:24] in bits 63:56. On success `rsp_lin` = (base + `req_ofs`) mod 2^32.
- R4: When granularity bit 55 is 1, the effective limit is {limit, 12'hFFF}. When bit 55 is 0, the effective limit is the 20-bit limit, zero-extended.
- R5: An offset greater than the effective limit faults with cause 1. An offset equal to the limit succeeds.
- R6: Present bit 47 equal to 0 faults with cause 2. This fault takes priority over a limit fault.
- R7: A global-table index of 0, or any index of 16 or more, faults with cause 3. This fault takes priority over causes 2 and 1. Local-table index 0 is an ordinary entry.
- R8: `req_ready` is 1 whenever the unit is out of reset. `rsp_valid` is 1 exactly in the cycle after a request is accepted, and one request can be accepted every cycle.
- R9: A table write with `tw_local` selecting the table and `tw_idx` selecting the entry is seen by a request presented in the next cycle. The write leaves the other table unchanged.
- R10: While `rst_n` is 0, `rsp_valid` and `req_ready` are 0. After reset every descriptor reads as zero, so any in-range lookup faults with cause 2.
- R11: A faulting response has `rsp_lin`=0 and a non-zero cause. A good response has cause 0 and `rsp_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit accepts a request |
| req_prot | input | 1 | 1 = table translation, 0 = flat segment*16 translation |
| req_sel | input | 16 | Segment value or selector |
| req_ofs | input | 32 | Offset |
| rsp_valid | output | 1 | Response present |
| rsp_lin | output | 32 | Linear address, 0 on fault |
| rsp_fault | output | 1 | Translation faulted |
| rsp_cause | output | 2 | 0 none, 1 limit, 2 not present, 3 null or out of range |
| tw_en | input | 1 | Table write enable |
| tw_local | input | 1 | 0 = global table, 1 = local table |
| tw_idx | input | 4 | Entry written |
| tw_data | input | 64 | Descriptor written |

## Verification
Almost all internal state sits in the two descriptor tables. A wrong or stale entry does not show on its own. It appears only on the response to a protected-mode request that reads that entry, one cycle after the request is accepted, as a wrong base, a wrong cause or a missing fault. For this reason the bench reads each entry it writes in the cycle right after the write. It also reads a neighbouring entry of the other table, so that a write landing in the wrong table or at the wrong index shows up at once. Limit checks are made at the exact limit and one byte past it, with granularity both off and on, because an error in the scaling moves only that one boundary.

// File: rtl/seg_xlate_pkg.sv
// Package: shared types for the segmented address translation unit.
// Assumes 64-bit descriptors with split base and limit fields.
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_LIMIT   = 2'd1,
        CAUSE_ABSENT  = 2'd2,
        CAUSE_BADSEL  = 2'd3
    } cause_e;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] lim_eff;
        logic        present;
    } desc_view_t;

endpackage

// File: rtl/seg_desc_table.sv
// Module: one descriptor table of ENTRIES 64-bit words.
// Write is synchronous; read is combinational, so a write is seen by a
// request in the following cycle. Reset clears every word to zero.
module seg_desc_table #(
    parameter int ENTRIES = 16,
    parameter int DESC_W  = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DESC_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DESC_W-1:0] rd_data
);

    logic [DESC_W-1:0] mem_q [ENTRIES];

    // Storage update: clear on reset, otherwise write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Read port: combinational lookup of the addressed entry.
    always_comb begin
        rd_data = mem_q[rd_idx];
    end

endmodule

// File: rtl/seg_desc_decode.sv
// Module: unpacks a 64-bit descriptor into base, scaled limit and presence.
// Assumes granularity flag at bit 55 and present flag at bit 47.
module seg_desc_decode
    import seg_xlate_pkg::*;
#(
    parameter int GRAN_SHIFT = 12
) (
    input  logic [63:0] desc,
    output desc_view_t  view
);

    logic [19:0] lim_raw;
    logic        gran;

    // Field unpacking and limit scaling.
    always_comb begin
        lim_raw      = {desc[51:48], desc[15:0]};
        gran         = desc[55];
        view.base    = {desc[63:56], desc[39:16]};
        view.present = desc[47];
        if (gran) begin
            view.lim_eff = {lim_raw, {GRAN_SHIFT{1'b1}}};
        end else begin
            view.lim_eff = {{GRAN_SHIFT{1'b0}}, lim_raw};
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
// Module: top of the segmented address translation unit.
// Accepts one request per cycle and answers one cycle later. Flat mode
// forms a 20-bit address; table mode looks up one of two descriptor tables,
// then checks selector range, presence and limit, in that priority.
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int SEL_IDX_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_prot,
    input  logic [15:0]       req_sel,
    input  logic [31:0]       req_ofs,
    output logic              rsp_valid,
    output logic [31:0]       rsp_lin,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    input  logic              tw_en,
    input  logic              tw_local,
    input  logic [IDX_W-1:0]  tw_idx,
    input  logic [63:0]       tw_data
);

    localparam logic [SEL_IDX_W-1:0] ENT_LIM = SEL_IDX_W'(ENTRIES);

    logic [SEL_IDX_W-1:0] sel_idx;
    logic                 sel_tbl;
    logic [63:0]          rd_desc [2];
    logic [63:0]          pick_desc;
    desc_view_t           view;
    logic [19:0]          flat_sum;
    logic [31:0]          lin_d;
    cause_e               cause_d;
    logic                 accept;
    logic                 ready_q;

    assign sel_idx = req_sel[15:3];
    assign sel_tbl = req_sel[2];
    assign accept  = req_valid && ready_q;
    assign req_ready = ready_q;

    // One table instance per indicator value.
    for (genvar t = 0; t < 2; t++) begin : g_tbl
        seg_desc_table #(
            .ENTRIES (ENTRIES),
            .DESC_W  (64)
        ) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tw_en && (tw_local == 1'(t))),
            .wr_idx  (tw_idx),
            .wr_data (tw_data),
            .rd_idx  (sel_idx[IDX_W-1:0]),
            .rd_data (rd_desc[t])
        );
    end

    // Table selection by the indicator bit.
    always_comb begin
        pick_desc = sel_tbl ? rd_desc[1] : rd_desc[0];
    end

    seg_desc_decode #(
        .GRAN_SHIFT (12)
    ) u_dec (
        .desc (pick_desc),
        .view (view)
    );

    // Translation and fault priority for the presented request.
    always_comb begin
        flat_sum = {req_sel, 4'h0} + {4'h0, req_ofs[15:0]};
        lin_d    = '0;
        cause_d  = CAUSE_NONE;
        if (!req_prot) begin
            lin_d = {12'h000, flat_sum};
        end else if ((sel_idx >= ENT_LIM) || (!sel_tbl && sel_idx == '0)) begin
            cause_d = CAUSE_BADSEL;
        end else if (!view.present) begin
            cause_d = CAUSE_ABSENT;
        end else if (req_ofs > view.lim_eff) begin
            cause_d = CAUSE_LIMIT;
        end else begin
            lin_d = view.base + req_ofs;
        end
    end

    // Handshake readiness: low in reset, high afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    // Response register: capture the result of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_lin   <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_NONE;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_lin   <= lin_d;
                rsp_fault <= (cause_d != CAUSE_NONE);
                rsp_cause <= cause_d;
            end
        end
    end

endmodule

// File: rtl/seg_xlate_chk.sv
// Module: protocol and result checker bound to the translation unit.
// Observes ports only; assumes synchronous active-low reset.
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_prot,
    input logic [15:0] req_sel,
    input logic        rsp_valid,
    input logic [31:0] rsp_lin,
    input logic        rsp_fault,
    input logic [1:0]  rsp_cause
);

    // R10: reset quiets the response and the handshake.
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !req_ready));

    // R8: one response exactly one cycle after each accepted request.
    assert_rsp_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid && req_ready)));

    // R11: a fault returns a zero address and a non-zero cause.
    assert_fault_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_lin == 32'h0 && rsp_cause != 2'd0));

    // R11: success carries cause zero.
    assert_ok_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));

    // R1: flat translation never faults and stays within 20 bits.
    assert_flat_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_prot) |=>
            (!rsp_fault && rsp_lin[31:20] == 12'h000));

    // R7: global null selector always faults as a bad selector.
    assert_null_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_prot && req_sel[15:2] == 14'h0) |=>
            (rsp_fault && rsp_cause == 2'd3));

endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_prot  (req_prot),
    .req_sel   (req_sel),
    .rsp_valid (rsp_valid),
    .rsp_lin   (rsp_lin),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause)
);

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for the translation unit. A driver task computes the
// expected response from the requirements and queues it; a monitor pops
// and compares on every valid response.
module seg_xlate_unit_tb_top;

    typedef struct {
        logic [31:0] lin;
        logic        fault;
        logic [1:0]  cause;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_prot = 1'b0;
    logic [15:0] req_sel = '0;
    logic [31:0] req_ofs = '0;
    logic        rsp_valid;
    logic [31:0] rsp_lin;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        tw_en = 1'b0;
    logic        tw_local = 1'b0;
    logic [3:0]  tw_idx = '0;
    logic [63:0] tw_data = '0;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];
    logic [63:0] gtab [16];
    logic [63:0] ltab [16];

    always #4 clk = ~clk;

    seg_xlate_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_prot  (req_prot),
        .req_sel   (req_sel),
        .req_ofs   (req_ofs),
        .rsp_valid (rsp_valid),
        .rsp_lin   (rsp_lin),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause),
        .tw_en     (tw_en),
        .tw_local  (tw_local),
        .tw_idx    (tw_idx),
        .tw_data   (tw_data)
    );

    function automatic logic [63:0] mk_desc(logic [31:0] base, logic [19:0] lim,
                                            logic gran, logic pres);
        return {base[31:24], gran, 3'b100, lim[19:16], pres, 7'b0010010,
                base[23:0], lim[15:0]};
    endfunction

    function automatic exp_t model(logic prot, logic [15:0] sel, logic [31:0] ofs);
        exp_t e;
        logic [19:0] s;
        logic [12:0] idx;
        logic [63:0] d;
        logic [19:0] lim;
        logic [31:0] eff;
        e.lin = '0; e.fault = 1'b0; e.cause = 2'd0; e.tag = "";
        if (!prot) begin
            s = {sel, 4'h0} + {4'h0, ofs[15:0]};
            e.lin = {12'h0, s};
            return e;
        end
        idx = sel[15:3];
        if (idx >= 13'd16 || (!sel[2] && idx == 13'd0)) begin
            e.fault = 1'b1; e.cause = 2'd3; return e;
        end
        d = sel[2] ? ltab[idx[3:0]] : gtab[idx[3:0]];
        lim = {d[51:48], d[15:0]};
        eff = d[55] ? {lim, 12'hFFF} : {12'h0, lim};
        if (!d[47]) begin
            e.fault = 1'b1; e.cause = 2'd2;
        end else if (ofs > eff) begin
            e.fault = 1'b1; e.cause = 2'd1;
        end else begin
            e.lin = {d[63:56], d[39:16]} + ofs;
        end
        return e;
    endfunction

    task automatic check(string tag, logic ok, string got, string want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", tag, got, want);
        end
    endtask

    task automatic send(string tag, logic prot, logic [15:0] sel, logic [31:0] ofs);
        exp_t e;
        @(negedge clk);
        tw_en = 1'b0;
        req_valid = 1'b1; req_prot = prot; req_sel = sel; req_ofs = ofs;
        e = model(prot, sel, ofs);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr(logic loc, logic [3:0] idx, logic [63:0] data);
        @(negedge clk);
        req_valid = 1'b0;
        tw_en = 1'b1; tw_local = loc; tw_idx = idx; tw_data = data;
        if (loc) ltab[idx] = data; else gtab[idx] = data;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; tw_en = 1'b0;
        end
    endtask

    // Monitor: compare each response against the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check("R8 unexpected response", 1'b0, "rsp_valid=1", "no response");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, rsp_lin == e.lin && rsp_fault == e.fault && rsp_cause == e.cause,
                      $sformatf("lin=%h fault=%0d cause=%0d", rsp_lin, rsp_fault, rsp_cause),
                      $sformatf("lin=%h fault=%0d cause=%0d", e.lin, e.fault, e.cause));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1600000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        for (int i = 0; i < 16; i++) begin
            gtab[i] = '0; ltab[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R10 reset valid", rsp_valid == 1'b0, $sformatf("%0d", rsp_valid), "0");
        check("R10 reset ready", req_ready == 1'b0, $sformatf("%0d", req_ready), "0");
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 ready after reset", req_ready == 1'b1, $sformatf("%0d", req_ready), "1");

        send("R10 cleared local entry", 1'b1, 16'h000C, 32'h0);
        send("R10 cleared global entry", 1'b1, 16'h0078, 32'h0);
        send("R1 flat basic", 1'b0, 16'h1234, 32'h0000_5678);
        send("R1 flat wrap", 1'b0, 16'hFFFF, 32'h0000_FFFF);
        send("R1 flat upper offset ignored", 1'b0, 16'h0100, 32'hABCD_0010);
        idle(1);

        wr(1'b0, 4'd1, mk_desc(32'h0010_0000, 20'h00FFF, 1'b0, 1'b1));
        send("R9 lookup right after write", 1'b1, 16'h0008, 32'h0000_0FFF);
        send("R5 one past byte limit", 1'b1, 16'h0008, 32'h0000_1000);
        send("R2 rpl bits ignored", 1'b1, 16'h000B, 32'h0000_0010);

        wr(1'b0, 4'd2, mk_desc(32'h1234_5678, 20'h00003, 1'b1, 1'b1));
        send("R4 granular at limit", 1'b1, 16'h0010, 32'h0000_3FFF);
        send("R4 granular past limit", 1'b1, 16'h0010, 32'h0000_4000);
        send("R3 base split assembly", 1'b1, 16'h0010, 32'h0000_0001);

        wr(1'b0, 4'd3, mk_desc(32'h0000_8000, 20'h00010, 1'b0, 1'b0));
        send("R6 absent beats limit", 1'b1, 16'h0018, 32'h0010_0000);
        send("R7 null selector", 1'b1, 16'h0000, 32'h0);
        send("R7 null with rpl", 1'b1, 16'h0003, 32'h0);
        send("R7 index 16 out of range", 1'b1, 16'h0080, 32'h0);
        send("R7 high index local", 1'b1, 16'hFFFC, 32'h0);

        wr(1'b1, 4'd0, mk_desc(32'hC000_0000, 20'h000FF, 1'b0, 1'b1));
        send("R7 local index 0 usable", 1'b1, 16'h0004, 32'h0000_00FF);
        send("R9 other table untouched", 1'b1, 16'h0008, 32'h0000_0020);
        wr(1'b1, 4'd1, mk_desc(32'h0200_0000, 20'h00FFF, 1'b0, 1'b1));
        send("R2 local table chosen", 1'b1, 16'h000C, 32'h0000_0004);
        send("R2 global same index", 1'b1, 16'h0008, 32'h0000_0004);

        wr(1'b0, 4'd4, mk_desc(32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1));
        send("R3 base plus offset wraps", 1'b1, 16'h0020, 32'h0000_2000);
        send("R4 full granular limit", 1'b1, 16'h0020, 32'hFFFF_FFFF);

        wr(1'b0, 4'd1, mk_desc(32'h0030_0000, 20'h0000F, 1'b0, 1'b1));
        send("R9 rewrite seen next cycle", 1'b1, 16'h0008, 32'h0000_000F);
        send("R5 rewritten limit exceeded", 1'b1, 16'h0008, 32'h0000_0010);
        send("R8 back to back flat", 1'b0, 16'h0001, 32'h0000_0001);
        idle(4);

        check("R8 all responses seen", sb_q.size() == 0,
              $sformatf("%0d pending", sb_q.size()), "0 pending");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule